// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block fetches the operand of an 8-bit accumulator processor with a 16-bit address space. The decoder names the addressing mode, and the block starts from the fetch pointer that follows the opcode and from the two index registers. It then issues one memory read per clock through a byte-wide port with combinational read data. It consumes the operand bytes that follow the opcode, resolves the effective address, and presents the operand byte with a one-cycle completion strobe.

The block latches mode, pointer and index values when a start is accepted, so these inputs may change freely while a fetch is in flight. The latency depends on the mode. It grows by one clock when an indexed sum carries out of the low address byte, and sums that stay in page zero wrap inside it.

Top module: `opf_seq`

## Requirements
- R1: Mode code 0 is immediate. The block reads the byte at the start pointer, and that byte is the operand. `done_o` rises 1 clock edge after the edge that samples `start_i`.
- R2: Mode 1 (page zero) uses the first byte B as address {0x00,B}. `done_o` rises after 2 edges.
- R3: Modes 2 and 3 (page zero plus X, plus Y) read at {0x00,(B+index) mod 256}. `done_o` rises after 3 edges.
- R4: Mode 4 (absolute) takes the first byte as the low address byte and the second byte as the high address byte. `done_o` rises after 3 edges.
- R5: Modes 5 and 6 (absolute plus X, plus Y) read at the 16-bit address plus the index, modulo 65536. `done_o` rises after 3 edges, or after 4 edges when the low-byte sum exceeds 0xFF.
- R6: Mode 7 (pre-indexed indirect) forms the pointer P=(B+X) mod 256. It reads the low address byte at {0x00,P} and the high byte at {0x00,(P+1) mod 256}. `done_o` rises after 5 edges.
- R7: Mode 8 (post-indexed indirect) reads a pointer at {0x00,B} and {0x00,(B+1) mod 256}, then adds Y to it modulo 65536. `done_o` rises after 4 edges, or after 5 edges when the low-byte sum exceeds 0xFF.
- R8: `done_o` is high for exactly one cycle, with `busy_o` low. `operand_o` carries the operand in that cycle and holds it until the next completion.
- R9: `start_i` is ignored while `busy_o` is high. Changes on `mode_i`, `pc_i`, `x_i` and `y_i` after acceptance have no effect on the running fetch.
- R10: After completion, `pc_o` equals the start pointer plus the bytes consumed, modulo 65536: 2 for modes 4, 5 and 6, and 1 for all other modes. `pc_o` changes by at most 1 per clock while busy and holds while idle.
- R11: Mode codes 9 to 15 behave exactly as immediate.
- R12: While `rst_ni` is low, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fetch; sampled only while idle |
| mode_i | input | 4 | Addressing mode code |
| pc_i | input | 16 | Pointer to the first operand byte |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o`, same cycle |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion strobe |
| operand_o | output | 8 | Operand byte |
| pc_o | output | 16 | Fetch pointer after consumed bytes |

## Verification
The sweep covers every mode code with varied indexes and start pointers, including pointers at 0xFFFE and 0xFFFF, whose sum in R10 must wrap to the bottom of memory. A design that carried into the high byte on page-zero indexed sums would read outside page zero, and one that let an indirect pointer at 0xFF fetch its high byte from 0x0100 would return the wrong operand. Both show up in the pointer-wrap cases. A design that skipped the extra cycle, or always took it, would fail the R5 and R7 latency counts on only one side of the carry. The bench also pulses start and scrambles the inputs in the cycle after acceptance, which catches a design that re-latches its inputs mid-fetch.

// File: rtl/opf_pkg.sv
`timescale 1ns/1ps
package opf_pkg;

  typedef enum logic [3:0] {
    AM_IMM  = 4'd0,
    AM_ZP   = 4'd1,
    AM_ZPX  = 4'd2,
    AM_ZPY  = 4'd3,
    AM_ABS  = 4'd4,
    AM_ABSX = 4'd5,
    AM_ABSY = 4'd6,
    AM_INDX = 4'd7,
    AM_INDY = 4'd8
  } am_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPND,   // first operand byte at pc
    ST_HIGH,   // second operand byte at pc
    ST_ZIDX,   // page-zero index add
    ST_PLO,    // pointer low read
    ST_PHI,    // pointer high read
    ST_CARRY,  // high-byte fix after carry
    ST_READ    // operand read
  } st_e;

  function automatic am_e am_norm(input logic [3:0] m);
    if (m > 4'd8) return AM_IMM;
    return am_e'(m);
  endfunction

  function automatic logic am_uses_x(input am_e m);
    return (m == AM_ZPX) || (m == AM_ABSX) || (m == AM_INDX);
  endfunction

  function automatic logic am_uses_y(input am_e m);
    return (m == AM_ZPY) || (m == AM_ABSY) || (m == AM_INDY);
  endfunction

endpackage

// File: rtl/opf_idx_add.sv
`timescale 1ns/1ps
module opf_idx_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] full;
  assign full    = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
endmodule

// File: rtl/opf_next_step.sv
`timescale 1ns/1ps
module opf_next_step
  import opf_pkg::*;
(
  input  st_e  st_i,
  input  am_e  mode_i,
  input  logic start_i,
  input  logic carry_i,
  output st_e  st_o
);
  always_comb begin
    st_o = ST_IDLE;
    case (st_i)
      ST_IDLE: st_o = start_i ? ST_OPND : ST_IDLE;
      ST_OPND: begin
        case (mode_i)
          AM_IMM:                  st_o = ST_IDLE;
          AM_ZP:                   st_o = ST_READ;
          AM_ZPX, AM_ZPY, AM_INDX: st_o = ST_ZIDX;
          AM_INDY:                 st_o = ST_PLO;
          default:                 st_o = ST_HIGH;
        endcase
      end
      ST_ZIDX:          st_o = (mode_i == AM_INDX) ? ST_PLO : ST_READ;
      ST_HIGH, ST_PHI:  st_o = carry_i ? ST_CARRY : ST_READ;
      ST_PLO:           st_o = ST_PHI;
      ST_CARRY:         st_o = ST_READ;
      default:          st_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/opf_addr_mux.sv
`timescale 1ns/1ps
module opf_addr_mux
  import opf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  st_e               st_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ea_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HW = ADDR_W - DATA_W;

  logic [DATA_W-1:0] ptr_next;
  assign ptr_next = ea_i[DATA_W-1:0] + 1'b1;  // wraps inside page zero

  always_comb begin
    case (st_i)
      ST_IDLE, ST_OPND, ST_HIGH: addr_o = pc_i;
      ST_PLO:                    addr_o = {{HW{1'b0}}, ea_i[DATA_W-1:0]};
      ST_PHI:                    addr_o = {{HW{1'b0}}, ptr_next};
      default:                   addr_o = ea_i;
    endcase
  end
endmodule

// File: rtl/opf_seq.sv
`timescale 1ns/1ps
module opf_seq
  import opf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] operand_o,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int HW = ADDR_W - DATA_W;

  st_e               st_q, st_d;
  am_e               mode_q, mode_in;
  logic [ADDR_W-1:0] pc_q, ea_q;
  logic [DATA_W-1:0] lo_q, idx_q, operand_q;
  logic              done_q;

  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_carry;

  assign mode_in = am_norm(mode_i);

  always_comb begin
    add_a = ea_q[DATA_W-1:0];
    add_b = '0;
    case (st_q)
      ST_HIGH, ST_ZIDX: add_b = idx_q;
      ST_PHI: begin
        add_a = lo_q;
        add_b = (mode_q == AM_INDY) ? idx_q : '0;
      end
      default: ;
    endcase
  end

  opf_idx_add #(.W(DATA_W)) u_add (
    .a_i     (add_a),
    .b_i     (add_b),
    .sum_o   (add_sum),
    .carry_o (add_carry)
  );

  opf_next_step u_next (
    .st_i    (st_q),
    .mode_i  (mode_q),
    .start_i (start_i),
    .carry_i (add_carry),
    .st_o    (st_d)
  );

  opf_addr_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_amux (
    .st_i   (st_q),
    .pc_i   (pc_q),
    .ea_i   (ea_q),
    .addr_o (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      mode_q    <= AM_IMM;
      pc_q      <= '0;
      ea_q      <= '0;
      lo_q      <= '0;
      idx_q     <= '0;
      operand_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      st_q   <= st_d;
      case (st_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_in;
          pc_q   <= pc_i;
          idx_q  <= am_uses_x(mode_in) ? x_i :
                    am_uses_y(mode_in) ? y_i : '0;
        end
        ST_OPND: begin
          pc_q <= pc_q + 1'b1;
          ea_q <= {{HW{1'b0}}, mem_rdata_i};
          if (mode_q == AM_IMM) begin
            operand_q <= mem_rdata_i;
            done_q    <= 1'b1;
          end
        end
        ST_HIGH: begin
          pc_q <= pc_q + 1'b1;
          ea_q <= {mem_rdata_i, add_sum};
        end
        ST_ZIDX:  ea_q[DATA_W-1:0] <= add_sum;
        ST_PLO:   lo_q <= mem_rdata_i;
        ST_PHI:   ea_q <= {mem_rdata_i, add_sum};
        ST_CARRY: ea_q[ADDR_W-1:DATA_W] <= ea_q[ADDR_W-1:DATA_W] + 1'b1;
        ST_READ: begin
          operand_q <= mem_rdata_i;
          done_q    <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign operand_o = operand_q;
  assign pc_o      = pc_q;
endmodule

// File: rtl/opf_seq_chk.sv
`timescale 1ns/1ps
module opf_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [3:0]        mode_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] pc_o
);
  localparam int HW = ADDR_W - DATA_W;

  logic [2:0] run_cnt;   // busy cycles already spent in this fetch
  logic [3:0] mode_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt  <= '0;
      mode_cap <= '0;
    end else begin
      if (!busy_o) run_cnt <= '0;
      else if (run_cnt != 3'd7) run_cnt <= run_cnt + 1'b1;
      if (!busy_o && start_i) mode_cap <= mode_i;
    end
  end

  p_start_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_imm_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && mode_i == 4'd0) |=> ##1 done_o);

  p_zp_page_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_cnt != 3'd0 && mode_cap >= 4'd1 && mode_cap <= 4'd3)
      |-> (mem_addr_o[ADDR_W-1:DATA_W] == {HW{1'b0}}));

  p_max_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_cnt < 3'd5));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_pc_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (pc_o == $past(pc_o) || pc_o == $past(pc_o) + 1'b1));

  p_pc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(pc_o));

  always_comb begin
    if (!rst_ni) p_reset_quiet_r12: assert (!busy_o);
  end
endmodule

bind opf_seq opf_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .mem_addr_o (mem_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pc_o       (pc_o)
);

// File: tb/opf_seq_bench.sv
`timescale 1ns/1ps
module opf_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  x = '0, y = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [7:0]  operand;
  logic [15:0] pc_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    logic [7:0] r;
    r = a[7:0] * 8'd13 + a[15:8] * 8'd7 + 8'h29;
    return r;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  opf_seq u_opf_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .mode_i      (mode),
    .pc_i        (pc),
    .x_i         (x),
    .y_i         (y),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .busy_o      (busy),
    .done_o      (done),
    .operand_o   (operand),
    .pc_o        (pc_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [3:0] m, input logic [15:0] p,
                     input logic [7:0] xv, input logic [7:0] yv, input bit poke);
    logic [7:0]  b1, b2, ptr, lo, hi, exp_op, prev_op;
    logic [15:0] ea, exp_pc;
    int n, cnt;
    bit got;
    string rq;
    rq = req_of(m);
    b1 = mem_f(p);
    b2 = mem_f(p + 16'd1);
    exp_pc = p + 16'd1;
    case (m)
      4'd1: begin ea = {8'h00, b1}; n = 2; end
      4'd2: begin ea = {8'h00, 8'(b1 + xv)}; n = 3; end
      4'd3: begin ea = {8'h00, 8'(b1 + yv)}; n = 3; end
      4'd4: begin ea = {b2, b1}; n = 3; exp_pc = p + 16'd2; end
      4'd5, 4'd6: begin
        ea = {b2, b1} + {8'h00, (m == 4'd5) ? xv : yv};
        n = ((9'(b1) + 9'((m == 4'd5) ? xv : yv)) > 9'd255) ? 4 : 3;
        exp_pc = p + 16'd2;
      end
      4'd7: begin
        ptr = b1 + xv;
        lo = mem_f({8'h00, ptr});
        hi = mem_f({8'h00, 8'(ptr + 8'd1)});
        ea = {hi, lo}; n = 5;
      end
      4'd8: begin
        lo = mem_f({8'h00, b1});
        hi = mem_f({8'h00, 8'(b1 + 8'd1)});
        ea = {hi, lo} + {8'h00, yv};
        n = ((9'(lo) + 9'(yv)) > 9'd255) ? 5 : 4;
      end
      default: begin ea = p; n = 1; end
    endcase
    exp_op = mem_f(ea);

    @(negedge clk);
    mode = m; pc = p; x = xv; y = yv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (poke) begin  // R9: restart attempt and scrambled inputs mid-fetch
      mode = 4'd0; pc = ~p; x = ~xv; y = ~yv; start = 1'b1;
    end else begin
      start = 1'b0;
    end
    cnt = 0; got = 0;
    while (!got && cnt < 12) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt++;
      if (done) got = 1;
    end
    check(got, "R8", "done seen", int'(got), 1);
    check(cnt == n, rq, $sformatf("latency mode %0d%s", m, poke ? " (R9 poke)" : ""), cnt, n);
    check(operand == exp_op, rq, $sformatf("operand mode %0d%s", m, poke ? " (R9 poke)" : ""),
          int'(operand), int'(exp_op));
    check(pc_out == exp_pc, "R10", $sformatf("pc after mode %0d", m), int'(pc_out), int'(exp_pc));
    check(!busy, "R8", "busy low with done", int'(busy), 0);
    prev_op = operand;
    @(posedge clk);
    @(negedge clk);
    check(!done, "R8", "done single cycle", int'(done), 0);
    check(operand == prev_op, "R8", "operand held", int'(operand), int'(prev_op));
  endtask

  initial begin
    logic [15:0] p;
    #3;
    check(!busy, "R12", "busy in reset", int'(busy), 0);
    check(!done, "R12", "done in reset", int'(done), 0);
    #20;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done, "R12", "idle after reset", int'({busy, done}), 0);

    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 40; k++) begin
        p = (k == 0) ? 16'hFFFF : (k == 1) ? 16'hFFFE : 16'(k * 16'h1357 + 16'h0100);
        run(4'(m), p, 8'(k * 29 + 3), 8'(k * 53 + 250), (k % 5) == 4);
      end
    end

    // pointer at 0xFF: high byte must come from 0x00 (R6, R7)
    p = 16'h0200;
    while (mem_f(p) != 8'hFF) p = p + 16'd1;
    run(4'd8, p, 8'h00, 8'h10, 1'b0);
    run(4'd8, p, 8'h00, 8'hF0, 1'b0);
    run(4'd7, p, 8'h00, 8'h00, 1'b0);
    run(4'd7, 16'h0300, 8'hFF - mem_f(16'h0300), 8'h00, 1'b0);
    // page-zero index wrap (R3)
    run(4'd2, 16'h0400, 8'hFF, 8'h00, 1'b0);
    run(4'd3, 16'h0400, 8'h00, 8'hFF, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule